// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal processor. On every clock it can multiply two signed 16-bit operands and then do one of three things with the product: load it into one of two 40-bit accumulators, add it to that accumulator, or subtract it from that accumulator. A multiply-accumulate finishes in a single cycle. There is no pipeline, so the updated accumulator can be read at the block's outputs right after the clock edge that performs the operation.

A fractional mode doubles the product. This removes the duplicated sign bit that appears when two Q15 values are multiplied, so the result lines up as Q31 in the accumulator. Each accumulator carries eight guard bits above bit 31, which lets a long sum of products grow past the 32-bit range without losing the true value.

A rounding option adds half of one high-word LSB to the result and then zeroes the low 16 bits. A separate saturate command clamps the selected accumulator into the signed 32-bit range. Without that command, sums wrap modulo 2^40, and a per-accumulator overflow flag records that a wrap happened. The 16-bit high word (bits 31..16) of either accumulator can be read on a dedicated output.

Top module: `frac_mac`

## Requirements
- R1: After reset, both accumulators read zero and both overflow flags read zero.
- R2: Operation code 1 (load) writes the signed product of `x_i` and `y_i` into the accumulator chosen by `sel_i` (0 selects A, 1 selects B). The result appears after the next clock edge, and the other accumulator is not changed. Each operand is sign-extended to 17 bits before the multiply.
- R3: When `frct_i` is 1, the product is shifted left by one bit before it is used. In particular, 0x8000 times 0x8000 gives 0x0080000000, with no clamping.
- R4: Operation code 2 (accumulate) adds the product to the selected accumulator in one cycle.
- R5: Operation code 3 (deduct) subtracts the product from the selected accumulator in one cycle.
- R6: When `clr_i` is 1 together with operation code 2 or 3, the selected accumulator is treated as zero before the add or subtract.
- R7: When `rnd_i` is 1 with operation code 1, 2 or 3, the value 2^15 is added to the 40-bit result, and then bits 15..0 of the stored result are forced to zero.
- R8: Results wrap modulo 2^40. An overflow flag (`ovf_a_o` for A, `ovf_b_o` for B) is set when the exact signed result falls outside the 40-bit range. The flag then stays set until a load or a clearing operation on that accumulator recomputes it.
- R9: When `sat_i` is 1, it overrides the operation code. The selected accumulator is clamped to 0x007FFFFFFF if above that value, or to 0xFF80000000 if below that value. A value already inside the range is left unchanged.
- R10: `hi_o` shows bits 31..16 of accumulator A when `rd_sel_i` is 0, and of accumulator B when `rd_sel_i` is 1.
- R11: 255 fractional products of 0x8000 times 0x8000 summed into one accumulator give 255·2^31 exactly, and the overflow flag stays clear.
- R12: With operation code 0 and `sat_i` at 0, both accumulators and both flags hold their values. This holds even if `clr_i`, `rnd_i` or the operands are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | 0 idle, 1 load product, 2 add product, 3 subtract product |
| sel_i | input | 1 | Target accumulator: 0 for A, 1 for B |
| x_i | input | 16 | Signed multiplicand |
| y_i | input | 16 | Signed multiplier |
| frct_i | input | 1 | Fractional mode: double the product |
| rnd_i | input | 1 | Round the result and zero its low word |
| clr_i | input | 1 | Use zero instead of the accumulator as the addend base |
| sat_i | input | 1 | Clamp the selected accumulator to the 32-bit range |
| rd_sel_i | input | 1 | Chooses which accumulator drives `hi_o` |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ovf_a_o | output | 1 | Sticky overflow flag of A |
| ovf_b_o | output | 1 | Sticky overflow flag of B |
| hi_o | output | 16 | High word (bits 31..16) of the chosen accumulator |

## Verification
The accumulators are visible directly at the ports. A wrong product, a wrong sign of the addend, or a stray write to the accumulator that was not selected therefore shows up as a value mismatch one edge after the operation that caused it. A bad overflow flag or a bad guard-bit path, by contrast, can stay hidden through hundreds of cycles of accumulation. For that reason the long 255-term and 256-term runs are checked at their last step. Operand sweeps across the sign and extreme values, repeated with and without fractional mode, expose any error in sign extension or in the doubling shift on the very next cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_ADD  = 2'd2,
        OP_SUB  = 2'd3
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [OP_W-1:0]  x_i,
    input  logic [OP_W-1:0]  y_i,
    input  logic             frct_i,
    output logic [ACC_W-1:0] prod_o
);
    localparam int EXT_W  = OP_W + 1;
    localparam int PROD_W = 2 * EXT_W;

    logic signed [EXT_W-1:0]  xe, ye;
    logic signed [PROD_W-1:0] raw;
    logic        [ACC_W-1:0]  wide;

    always_comb begin
        xe     = {x_i[OP_W-1], x_i};
        ye     = {y_i[OP_W-1], y_i};
        raw    = xe * ye;
        wide   = {{(ACC_W-PROD_W){raw[PROD_W-1]}}, raw};
        prod_o = frct_i ? {wide[ACC_W-2:0], 1'b0} : wide;
    end
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
    parameter int ACC_W   = 40,
    parameter int RND_BIT = 15
) (
    input  logic [ACC_W-1:0] base_i,
    input  logic [ACC_W-1:0] addend_i,
    input  logic             sub_i,
    input  logic             rnd_i,
    output logic [ACC_W-1:0] res_o,
    output logic             ovf_o
);
    localparam int WIDE_W = ACC_W + 2;
    localparam logic [WIDE_W-1:0] RND_K = WIDE_W'(1) << RND_BIT;
    localparam logic [ACC_W-1:0]  LOW_M = (ACC_W'(1) << (RND_BIT + 1)) - ACC_W'(1);

    logic [WIDE_W-1:0] b_w, a_w, sum_w;

    always_comb begin
        b_w   = {{2{base_i[ACC_W-1]}}, base_i};
        a_w   = {{2{addend_i[ACC_W-1]}}, addend_i};
        sum_w = b_w + (sub_i ? (~a_w + WIDE_W'(1)) : a_w) + (rnd_i ? RND_K : '0);
        ovf_o = !((sum_w[WIDE_W-1:ACC_W-1] == '0) || (sum_w[WIDE_W-1:ACC_W-1] == '1));
        res_o = sum_w[ACC_W-1:0];
        if (rnd_i) begin
            res_o = res_o & ~LOW_M;
        end
    end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
    parameter int ACC_W = 40,
    parameter int SAT_W = 32
) (
    input  logic [ACC_W-1:0] val_i,
    output logic [ACC_W-1:0] val_o
);
    localparam int TOP_W = ACC_W - SAT_W + 1;
    localparam logic [ACC_W-1:0] POS_LIM = {{TOP_W{1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {{TOP_W{1'b1}}, {(SAT_W-1){1'b0}}};

    logic [TOP_W-1:0] top;

    always_comb begin
        top = val_i[ACC_W-1:SAT_W-1];
        if ((top == '0) || (top == '1)) begin
            val_o = val_i;
        end else if (val_i[ACC_W-1]) begin
            val_o = NEG_LIM;
        end else begin
            val_o = POS_LIM;
        end
    end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
    import mac_pkg::*;
#(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          op_i,
    input  logic                sel_i,
    input  logic [OP_W-1:0]     x_i,
    input  logic [OP_W-1:0]     y_i,
    input  logic                frct_i,
    input  logic                rnd_i,
    input  logic                clr_i,
    input  logic                sat_i,
    input  logic                rd_sel_i,
    output logic [2*OP_W+GUARD_W-1:0] acc_a_o,
    output logic [2*OP_W+GUARD_W-1:0] acc_b_o,
    output logic                ovf_a_o,
    output logic                ovf_b_o,
    output logic [OP_W-1:0]     hi_o
);
    localparam int SAT_W = 2 * OP_W;
    localparam int ACC_W = SAT_W + GUARD_W;
    localparam int N_ACC = 2;

    typedef struct packed {
        logic [N_ACC-1:0][ACC_W-1:0] acc;
        logic [N_ACC-1:0]            ovf;
    } state_t;

    state_t st_d, st_q;

    mac_op_e          op;
    logic [ACC_W-1:0] prod, base, res;
    logic             ovf_w, fresh;
    logic [N_ACC-1:0][ACC_W-1:0] clamped;

    assign op = mac_op_e'(op_i);

    mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
        .x_i    (x_i),
        .y_i    (y_i),
        .frct_i (frct_i),
        .prod_o (prod)
    );

    mac_addsub #(.ACC_W(ACC_W), .RND_BIT(OP_W-1)) u_add (
        .base_i   (base),
        .addend_i (prod),
        .sub_i    (op == OP_SUB),
        .rnd_i    (rnd_i),
        .res_o    (res),
        .ovf_o    (ovf_w)
    );

    for (genvar g = 0; g < N_ACC; g++) begin : g_sat
        mac_sat #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_sat (
            .val_i (st_q.acc[g]),
            .val_o (clamped[g])
        );
    end

    always_comb begin
        st_d  = st_q;
        fresh = (op == OP_LOAD) || clr_i;
        base  = fresh ? '0 : st_q.acc[sel_i];
        if (sat_i) begin
            st_d.acc[sel_i] = clamped[sel_i];
        end else if (op != OP_IDLE) begin
            st_d.acc[sel_i] = res;
            st_d.ovf[sel_i] = fresh ? ovf_w : (st_q.ovf[sel_i] | ovf_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_a_o = st_q.acc[0];
    assign acc_b_o = st_q.acc[1];
    assign ovf_a_o = st_q.ovf[0];
    assign ovf_b_o = st_q.ovf[1];
    assign hi_o    = st_q.acc[rd_sel_i][SAT_W-1:SAT_W-OP_W];
endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
    parameter int ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_i,
    input logic             sel_i,
    input logic             frct_i,
    input logic             rnd_i,
    input logic             sat_i,
    input logic [ACC_W-1:0] acc_a_o,
    input logic [ACC_W-1:0] acc_b_o,
    input logic             ovf_a_o,
    input logic             ovf_b_o
);
    localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'(64'h7FFFFFFF);
    localparam logic signed [ACC_W-1:0] LO_LIM = -HI_LIM - ACC_W'(1);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd0 && !sat_i) |=> ($stable(acc_a_o) && $stable(acc_b_o)
                                      && $stable(ovf_a_o) && $stable(ovf_b_o)));

    p_other_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i) |=> ($stable(acc_b_o) && $stable(ovf_b_o)));

    p_sat_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_i && !sel_i) |=> ($signed(acc_a_o) <= HI_LIM && $signed(acc_a_o) >= LO_LIM));

    p_round_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_i && !sat_i && op_i != 2'd0 && sel_i) |=> (acc_b_o[15:0] == 16'h0));

    p_load_no_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd1 && !sat_i && !sel_i) |=> !ovf_a_o);

    p_frct_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'd1 && frct_i && !sat_i && !sel_i) |=> !acc_a_o[0]);
endmodule

bind frac_mac frac_mac_chk #(.ACC_W(ACC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .sel_i   (sel_i),
    .frct_i  (frct_i),
    .rnd_i   (rnd_i),
    .sat_i   (sat_i),
    .acc_a_o (acc_a_o),
    .acc_b_o (acc_b_o),
    .ovf_a_o (ovf_a_o),
    .ovf_b_o (ovf_b_o)
);

// File: tb/frac_mac_tb.sv
module frac_mac_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op_i;
    logic        sel_i, frct_i, rnd_i, clr_i, sat_i, rd_sel_i;
    logic [15:0] x_i, y_i;
    logic [39:0] acc_a_o, acc_b_o;
    logic        ovf_a_o, ovf_b_o;
    logic [15:0] hi_o;

    always #4 clk = ~clk;

    frac_mac u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_i(sel_i), .x_i(x_i), .y_i(y_i),
        .frct_i(frct_i), .rnd_i(rnd_i), .clr_i(clr_i), .sat_i(sat_i), .rd_sel_i(rd_sel_i),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .ovf_a_o(ovf_a_o), .ovf_b_o(ovf_b_o),
        .hi_o(hi_o)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    longint ea = 0, eb = 0;
    bit oa = 0, ob = 0;
    localparam longint P40 = 64'sd1 <<< 40;
    localparam longint P39 = 64'sd1 <<< 39;

    function automatic longint sx40(input longint v);
        longint m = v & (P40 - 1);
        if (m >= P39) m = m - P40;
        return m;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, sx40(longint'(acc_a_o)), ea);
        chk(tag, sx40(longint'(acc_b_o)), eb);
        chk(tag, longint'(ovf_a_o), longint'(oa));
        chk(tag, longint'(ovf_b_o), longint'(ob));
    endtask

    task automatic idle_inputs();
        op_i = 2'd0; sel_i = 0; frct_i = 0; rnd_i = 0; clr_i = 0; sat_i = 0;
        x_i = '0; y_i = '0;
    endtask

    // one operation, expected values from the requirement arithmetic
    task automatic apply(input int op, input bit s, input int x, input int y,
                         input bit fr, input bit rn, input bit cl, input bit st);
        longint cur, p, r;
        bit ov, oldf;
        op_i = 2'(op); sel_i = s; x_i = 16'(x); y_i = 16'(y);
        frct_i = fr; rnd_i = rn; clr_i = cl; sat_i = st;
        cur  = s ? eb : ea;
        oldf = s ? ob : oa;
        r = cur; ov = oldf;
        if (st) begin
            if (cur > 64'sh7FFFFFFF) r = 64'sh7FFFFFFF;
            else if (cur < -64'sh80000000) r = -64'sh80000000;
        end else if (op != 0) begin
            p = longint'($signed(16'(x))) * longint'($signed(16'(y)));
            if (fr) p = p * 2;
            r = (op == 1 || cl) ? 0 : cur;
            r = (op == 3) ? r - p : r + p;
            if (rn) r = r + 32768;
            ov = (r >= P39) || (r < -P39);
            r = sx40(r);
            if (rn) r = r & ~64'hFFFF;
            if (!(op == 1 || cl)) ov = ov | oldf;
        end
        if (s) begin eb = r; ob = ov; end else begin ea = r; oa = ov; end
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    int vals[10] = '{0, 1, -1, 32767, -32768, 4660, -17185, 2, -2, 16384};

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rd_sel_i = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_all("R1 reset");

        // R2 / R3: load sweep over both accumulators and both modes
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                for (int f = 0; f < 2; f++) begin
                    apply(1, bit'((i + j) & 1), vals[i], vals[j], bit'(f), 0, 0, 0);
                    chk_all(f ? "R3 frct load" : "R2 load");
                end

        // R4 / R5 / R7: accumulate and deduct chains on B
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++) begin
                apply(((i + j) % 2) ? 3 : 2, 1, vals[i], vals[j], bit'(j & 1),
                      bit'((i * 10 + j) % 7 == 0), 0, 0);
                chk_all(((i + j) % 2) ? "R5 deduct" : "R4 accumulate");
            end

        // R3 extreme product
        apply(1, 0, -32768, -32768, 1, 0, 0, 0);
        chk("R3 min*min", sx40(longint'(acc_a_o)), 64'sh0080000000);

        // R6 clear with accumulate and deduct
        apply(2, 0, 3, 5, 0, 0, 1, 0);
        chk("R6 clr add", sx40(longint'(acc_a_o)), 15);
        apply(3, 0, 3, 5, 0, 0, 1, 0);
        chk("R6 clr sub", sx40(longint'(acc_a_o)), -15);

        // R7 literal rounding
        apply(1, 0, 16'h0100, 16'h0081, 0, 1, 0, 0);
        chk("R7 round", sx40(longint'(acc_a_o)), 64'sh10000);

        // R11 guard bits: 255 full-scale products
        apply(2, 0, -32768, -32768, 1, 0, 1, 0);
        for (int k = 1; k < 255; k++) apply(2, 0, -32768, -32768, 1, 0, 0, 0);
        chk("R11 guard sum", sx40(longint'(acc_a_o)), 255 * (64'sd1 <<< 31));
        chk("R11 no ovf", longint'(ovf_a_o), 0);

        // R8 wrap on the 256th term
        apply(2, 0, -32768, -32768, 1, 0, 0, 0);
        chk("R8 wrap", sx40(longint'(acc_a_o)), -P39);
        chk("R8 flag", longint'(ovf_a_o), 1);

        // R12 idle with noisy inputs
        op_i = 2'd0; clr_i = 1; rnd_i = 1; x_i = 16'h7FFF; y_i = 16'h7FFF; sel_i = 0;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk_all("R12 idle hold");

        // R9 negative clamp, then sticky flag check and load clear
        apply(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R9 neg clamp", sx40(longint'(acc_a_o)), -64'sh80000000);
        chk("R8 sticky", longint'(ovf_a_o), 1);
        apply(1, 0, 1, 1, 0, 0, 0, 0);
        chk("R8 load clears", longint'(ovf_a_o), 0);

        // R9 positive clamp, in-range hold, priority over op
        apply(1, 1, -32768, -32768, 1, 0, 0, 0);
        apply(2, 1, 100, 100, 0, 0, 0, 1);
        chk("R9 pos clamp", sx40(longint'(acc_b_o)), 64'sh7FFFFFFF);
        apply(2, 1, 100, 100, 0, 0, 0, 1);
        chk("R9 in range", sx40(longint'(acc_b_o)), 64'sh7FFFFFFF);
        apply(3, 1, 1, 1, 0, 0, 0, 0);
        chk_all("R5 after clamp");

        // R10 high word read
        apply(1, 0, 16'h1234, 16'h0100, 0, 0, 0, 0);
        apply(1, 1, -32768, 16'h4000, 1, 0, 0, 0);
        for (int r = 0; r < 2; r++) begin
            rd_sel_i = bit'(r);
            #1;
            chk("R10 hi word", longint'(hi_o), ((r ? eb : ea) >>> 16) & 64'hFFFF);
        end
        chk_all("R10 state");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule